// File: doc/BRIEF.md
# Powered-Device Low-Power Mode Controller

This block decides whether a powered device is running normally or resting in one of two reduced-power states. It watches three active-low control lines (sleep request, ultra-low-power select and wake request). A falling edge on the sleep request while awake moves it to sleep, or to ultra-low-power if the select line is low at that moment. A falling edge on the wake request brings it back. The step-down converter and linear regulator enable is high only while awake. The isolation path to the converter stays on in every state, so it needs no output here.

While resting, the block drives a pulse-width-modulated enable for the indicator LED. In ultra-low-power it also produces a slow on/off enable for an internal keep-alive current, so that the supply equipment keeps seeing a valid load. A hysteretic signature-hold detector runs beside the mode logic. When its strap allows it, it turns on when the port current drops below a low mark and turns off when the current climbs above a high mark. While it is on, the same keep-alive pulses are requested. All timing is counted in clock cycles, and every count is a parameter.

Top module: `pd_lowpower_ctrl`

## Requirements
- R1: A falling edge on `sleep_n` while the mode is wake (`mode_o` = 2'b00), with `ulp_n` high, moves the mode to sleep (2'b01).
- R2: The same edge with `ulp_n` low moves the mode to ultra-low-power (2'b10).
- R3: A falling edge on `sleep_n` while already in sleep or ultra-low-power leaves the mode unchanged. Rising edges on any control input have no effect.
- R4: A falling edge on `wake_n` returns the mode to wake from either low-power mode. In wake it has no effect.
- R5: `conv_en` is high exactly when the mode is wake.
- R6: In sleep and ultra-low-power, `led_en` repeats a pattern of `LED_PERIOD` cycles, high for the first `LED_HIGH` of them. In wake it is low.
- R7: In ultra-low-power, `sig_cur_en` repeats `KA_ON` cycles high, then `KA_OFF` cycles low. In sleep, with the hold detector off, it stays low.
- R8: With `sig_strap_en` high, `sig_hold_o` rises one cycle after `port_cur_low` is seen. It stays high until `port_cur_high` is seen. With the strap low, it is low and cannot rise.
- R9: While `sig_hold_o` is high, `sig_cur_en` follows the keep-alive pattern of R7 in any mode.
- R10: Each time the LED pattern or the keep-alive pattern starts, it starts at the first cycle of its high phase.
- R11: The control inputs pass through two synchronizing flops. A mode change appears after the third rising clock edge following the input's fall.
- R12: After reset the mode is wake, `conv_en` is 1, and `led_en`, `sig_cur_en` and `sig_hold_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Sleep request, active on falling edge, asynchronous |
| ulp_n | input | 1 | Ultra-low-power select, low selects it, asynchronous |
| wake_n | input | 1 | Wake request, active on falling edge, asynchronous |
| sig_strap_en | input | 1 | Strap enabling the signature-hold detector |
| port_cur_low | input | 1 | Port current below the low mark |
| port_cur_high | input | 1 | Port current above the high mark |
| conv_en | output | 1 | Converter and regulator enable |
| led_en | output | 1 | Indicator LED enable |
| sig_cur_en | output | 1 | Keep-alive current enable |
| mode_o | output | 2 | Current mode: 00 wake, 01 sleep, 10 ultra-low-power |
| sig_hold_o | output | 1 | Signature-hold detector active |

## Verification
On entry to ultra-low-power, the LED pattern and the keep-alive pattern both start in the same cycle and then run side by side on counters of different lengths. The bench enters that mode and compares both enables at every cycle against their own modulo schedules. It then leaves the mode part way through both patterns and re-enters it, to show that both restart together in their high phase instead of resuming. The signature-hold detector is also driven in wake, where its keep-alive pulses must appear while the LED stays dark.

// File: rtl/pd_lp_pkg.sv
package pd_lp_pkg;

    typedef enum logic [1:0] {
        MODE_WAKE  = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_ULP   = 2'b10
    } pd_mode_e;

    // Synchronized control levels, active low as on the pins
    typedef struct packed {
        logic wake_lvl;
        logic ulp_lvl;
        logic sleep_lvl;
    } pd_ctl_lvl_t;

    localparam int unsigned NUM_CTL = 3;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pd_ctl_sync.sv
module pd_ctl_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '1;
                    else     stage_q[k] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '1;
                    else     stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm
    import pd_lp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pd_ctl_lvl_t lvl,
    output pd_mode_e    mode
);
    pd_mode_e mode_q, mode_d;
    logic     sleep_prev_q, wake_prev_q;
    logic     sleep_fall, wake_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_prev_q <= 1'b1;
            wake_prev_q  <= 1'b1;
            mode_q       <= MODE_WAKE;
        end else begin
            sleep_prev_q <= lvl.sleep_lvl;
            wake_prev_q  <= lvl.wake_lvl;
            mode_q       <= mode_d;
        end
    end

    assign sleep_fall = sleep_prev_q & ~lvl.sleep_lvl;
    assign wake_fall  = wake_prev_q  & ~lvl.wake_lvl;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_WAKE:  if (sleep_fall) mode_d = lvl.ulp_lvl ? MODE_SLEEP : MODE_ULP;
            MODE_SLEEP,
            MODE_ULP:   if (wake_fall)  mode_d = MODE_WAKE;
            default:    mode_d = MODE_WAKE;
        endcase
    end

    assign mode = mode_q;

    // R1
    wake_to_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WAKE && sleep_fall && lvl.ulp_lvl) |=> (mode_q == MODE_SLEEP));
    // R2
    wake_to_ulp_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WAKE && sleep_fall && !lvl.ulp_lvl) |=> (mode_q == MODE_ULP));
    // R3
    lp_entry_from_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_WAKE) |=> (mode_q == $past(mode_q) || mode_q == MODE_WAKE));
    // R4
    wake_return_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_WAKE && wake_fall) |=> (mode_q == MODE_WAKE));
endmodule

// File: rtl/pd_pattern_gen.sv
module pd_pattern_gen #(
    parameter int unsigned PERIOD = 4000,
    parameter int unsigned HIGH   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic out
);
    localparam int unsigned CW = pd_lp_pkg::cnt_w(PERIOD);
    localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign out = run && (cnt_q < HIGH_C);

    // R10
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run)) |-> out);
    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/pd_sig_hold.sv
module pd_sig_hold (
    input  logic clk,
    input  logic rst,
    input  logic strap_en,
    input  logic cur_low,
    input  logic cur_high,
    output logic hold
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst || !strap_en) hold_q <= 1'b0;
        else if (!hold_q && cur_low) hold_q <= 1'b1;
        else if (hold_q && cur_high) hold_q <= 1'b0;
    end

    assign hold = hold_q;

    // R8
    strap_off_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_en |=> !hold_q);
    // R8
    no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && !cur_low) |=> !hold_q);
    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !cur_high && strap_en) |=> hold_q);
endmodule

// File: rtl/pd_lowpower_ctrl.sv
module pd_lowpower_ctrl
    import pd_lp_pkg::*;
#(
    parameter int unsigned LED_PERIOD  = 4000,
    parameter int unsigned LED_HIGH    = 1000,
    parameter int unsigned KA_ON       = 88000,
    parameter int unsigned KA_OFF      = 237000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_n,
    input  logic       ulp_n,
    input  logic       wake_n,
    input  logic       sig_strap_en,
    input  logic       port_cur_low,
    input  logic       port_cur_high,
    output logic       conv_en,
    output logic       led_en,
    output logic       sig_cur_en,
    output logic [1:0] mode_o,
    output logic       sig_hold_o
);
    localparam int unsigned KA_PERIOD = KA_ON + KA_OFF;

    logic [NUM_CTL-1:0] lvl_vec;
    pd_ctl_lvl_t        lvl;
    pd_mode_e           mode;
    logic               hold;
    logic               led_run, ka_run;

    pd_ctl_sync #(.WIDTH(NUM_CTL), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({wake_n, ulp_n, sleep_n}),
        .dout (lvl_vec)
    );

    assign lvl = pd_ctl_lvl_t'(lvl_vec);

    pd_mode_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .mode (mode)
    );

    pd_sig_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .strap_en (sig_strap_en),
        .cur_low  (port_cur_low),
        .cur_high (port_cur_high),
        .hold     (hold)
    );

    assign led_run = (mode != MODE_WAKE);
    assign ka_run  = (mode == MODE_ULP) || hold;

    pd_pattern_gen #(.PERIOD(LED_PERIOD), .HIGH(LED_HIGH)) u_led (
        .clk (clk),
        .rst (rst),
        .run (led_run),
        .out (led_en)
    );

    pd_pattern_gen #(.PERIOD(KA_PERIOD), .HIGH(KA_ON)) u_ka (
        .clk (clk),
        .rst (rst),
        .run (ka_run),
        .out (sig_cur_en)
    );

    assign conv_en    = (mode == MODE_WAKE);
    assign mode_o     = mode;
    assign sig_hold_o = hold;

    // R5
    led_conv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        led_en |-> !conv_en);
    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP && !hold) |-> !sig_cur_en);
endmodule

// File: tb/pd_lowpower_ctrl_tb_top.sv
module pd_lowpower_ctrl_tb_top;
    localparam int LP = 8, LH = 2, KON = 5, KOFF = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic sleep_n = 1'b1, ulp_n = 1'b1, wake_n = 1'b1;
    logic strap = 1'b0, cur_low = 1'b0, cur_high = 1'b0;
    logic conv_en, led_en, sig_cur_en, sig_hold;
    logic [1:0] mode;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pd_lowpower_ctrl #(.LED_PERIOD(LP), .LED_HIGH(LH), .KA_ON(KON), .KA_OFF(KOFF)) dut_i (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .ulp_n(ulp_n), .wake_n(wake_n),
        .sig_strap_en(strap), .port_cur_low(cur_low), .port_cur_high(cur_high),
        .conv_en(conv_en), .led_en(led_en), .sig_cur_en(sig_cur_en),
        .mode_o(mode), .sig_hold_o(sig_hold)
    );

    // {action(1 sleep pulse, 2 wake pulse), ulp_n level, expected mode}
    localparam logic [4:0] VEC [9] = '{
        {2'd1, 1'b1, 2'b01},  // R1
        {2'd1, 1'b1, 2'b01},  // R3 sleep again ignored
        {2'd2, 1'b1, 2'b00},  // R4
        {2'd1, 1'b0, 2'b10},  // R2
        {2'd1, 1'b1, 2'b10},  // R3 in ULP ignored
        {2'd2, 1'b1, 2'b00},  // R4
        {2'd2, 1'b1, 2'b00},  // R4 wake in wake ignored
        {2'd1, 1'b0, 2'b10},  // R2
        {2'd2, 1'b1, 2'b00}   // R4
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nstep(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        nstep(3);
        rst = 1'b0;
        nstep(1);
        check("R12 mode", mode, 0);
        check("R12 conv_en", conv_en, 1);
        check("R12 led_en", led_en, 0);
        check("R12 sig_cur_en", sig_cur_en, 0);
        check("R12 sig_hold", sig_hold, 0);

        for (int i = 0; i < 9; i++) begin
            ulp_n = VEC[i][2];
            if (VEC[i][4:3] == 2'd1) sleep_n = 1'b0; else wake_n = 1'b0;
            nstep(4);
            sleep_n = 1'b1; wake_n = 1'b1;
            nstep(4);
            check("R1/R2/R3/R4 vector mode", mode, VEC[i][1:0]);
            check("R5 conv_en vs mode", conv_en, (VEC[i][1:0] == 2'b00) ? 1 : 0);
        end

        // Sleep entry latency and LED pattern
        ulp_n = 1'b1; sleep_n = 1'b0;
        nstep(2);
        check("R11 mode before third edge", mode, 0);
        nstep(1);
        check("R11 R1 mode after third edge", mode, 1);
        for (int j = 0; j < 16; j++) begin
            check("R6 led_en sleep", led_en, ((j % LP) < LH) ? 1 : 0);
            check("R7 sig_cur_en sleep", sig_cur_en, 0);
            check("R5 conv_en sleep", conv_en, 0);
            nstep(1);
        end
        sleep_n = 1'b1;
        wake_n = 1'b0;
        nstep(3);
        check("R4 mode wake", mode, 0);
        check("R6 led_en wake", led_en, 0);
        wake_n = 1'b1;
        nstep(3);

        // ULP: LED and keep-alive patterns side by side
        ulp_n = 1'b0; sleep_n = 1'b0;
        nstep(3);
        check("R2 mode ulp", mode, 2);
        for (int j = 0; j < 24; j++) begin
            check("R6 led_en ulp", led_en, ((j % LP) < LH) ? 1 : 0);
            check("R7 sig_cur_en ulp", sig_cur_en, ((j % (KON + KOFF)) < KON) ? 1 : 0);
            nstep(1);
        end
        sleep_n = 1'b1; ulp_n = 1'b1;
        nstep(7);
        wake_n = 1'b0;
        nstep(3);
        check("R4 mode wake from ulp", mode, 0);
        check("R7 sig_cur_en wake", sig_cur_en, 0);
        wake_n = 1'b1;
        nstep(3);

        // Re-entry restarts both patterns
        ulp_n = 1'b0; sleep_n = 1'b0;
        nstep(3);
        for (int j = 0; j < 12; j++) begin
            check("R10 led_en restart", led_en, ((j % LP) < LH) ? 1 : 0);
            check("R10 sig_cur_en restart", sig_cur_en, (j < KON) ? 1 : 0);
            nstep(1);
        end
        sleep_n = 1'b1; ulp_n = 1'b1;
        wake_n = 1'b0;
        nstep(3);
        wake_n = 1'b1;
        nstep(3);
        check("R4 mode wake again", mode, 0);

        // Signature-hold detector in wake
        strap = 1'b1; cur_low = 1'b1;
        nstep(1);
        check("R8 hold entry", sig_hold, 1);
        check("R9 sig_cur_en at hold start", sig_cur_en, 1);
        check("R9 led_en stays low", led_en, 0);
        cur_low = 1'b0;
        nstep(5);
        check("R8 hold kept mid-band", sig_hold, 1);
        check("R9 sig_cur_en off phase", sig_cur_en, 0);
        nstep(7);
        check("R9 sig_cur_en new period", sig_cur_en, 1);
        cur_high = 1'b1;
        nstep(1);
        check("R8 hold exit", sig_hold, 0);
        check("R9 sig_cur_en after exit", sig_cur_en, 0);
        cur_high = 1'b0;
        strap = 1'b0; cur_low = 1'b1;
        nstep(2);
        check("R8 strap off blocks", sig_hold, 0);
        cur_low = 1'b0;
        nstep(1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule